// File: doc/BRIEF.md
# Variable-Length PWM Timer With Shadow Reload

This block is a free-running 16-bit counter driving a group of PWM channels. The PWM period is set at run time to 2^8, 2^9, 2^10 or 2^11 counts by a two-bit length field. A sticky period-overflow flag marks each period boundary and can raise a maskable interrupt. Each channel holds a 16-bit compare value. A channel can be switched to a full 16-bit mode, in which it compares against the whole counter and takes no notice of the length field.

Every channel also has a 16-bit shadow reload register. In the 9, 10 and 11-bit lengths, the shadow value is copied into the compare register at each period boundary, so a new duty cycle never starts partway through a period. The shadow and compare registers share the same two byte addresses. An access-select bit in the control register decides which of the two a bus read or write reaches. Software drives the block through a simple register bus: address, write data, write strobe and combinational read data.

Top module: `vpwm_core`

## Requirements
- R1: Length field encoding in control bits 1:0: 0 gives 8 bits, 1 gives 9, 2 gives 10 and 3 gives 11. A non-wide channel drives its output low while (counter AND (2^L-1)) is below its 16-bit compare value, and high otherwise.
- R2: On the clock edge where the low L counter bits are all ones, the overflow flag (control bit 5) becomes 1. After reset is released with an 8-bit length, this is edge 258.
- R3: The overflow flag is sticky. A control write with bit 5 at 1 sets it, and a control write with bit 5 at 0 clears it. Nothing else clears it.
- R4: irq_o is high exactly while the overflow flag and the interrupt enable (control bit 6) are both 1.
- R5: Channel n's compare low and high bytes are at addresses 2+2n and 3+2n. With access-select (control bit 7) at 0, these addresses read and write the compare register. With it at 1, they reach the shadow reload register.
- R6: In the 9, 10 and 11-bit lengths, a non-wide channel loads its shadow value into its compare register on every overflow edge. On that edge the load takes precedence over a direct compare write.
- R7: With an 8-bit length, and on any wide channel, the shadow register never changes the compare register.
- R8: Address 1 bit n places channel n in 16-bit mode. Such a channel is low while the full counter is below its compare value, whatever the length field says.
- R9: Control bits 4:2 always read 0. Every register resets to 0, and unused addresses read 0.
- R10: When an overflow edge and a control write clearing the flag happen in the same cycle, the flag ends up set.
- R11: Reset is asynchronous and active low. Its release takes effect on the second rising clock edge, and the counter first increments on the third edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| addr_i | input | 4 | Register address |
| wdata_i | input | 8 | Write data |
| wr_en_i | input | 1 | Write strobe, one write per cycle |
| rdata_o | output | 8 | Read data for addr_i, combinational |
| pwm_o | output | 4 | PWM outputs, one per channel |
| irq_o | output | 1 | Interrupt request |

## Verification
The hardest case to reach is a clearing control write that lands on the exact edge where the period overflows. The bench keeps its own copy of the counter, waits until that copy shows all ones in the low eight bits, and issues the clearing write on that cycle. Shadow loads need a comparable setup, since they only show at a period boundary. The bench programs a shadow value, clears the flag, polls until the flag comes back, and then reads the compare bytes. The same sequence is repeated with the 8-bit length and with a wide channel, to confirm that no load takes place in those cases. Long random runs with occasional length changes then compare every output against the bench's own model on every cycle.

// File: rtl/vpwm_pkg.sv
package vpwm_pkg;
  localparam int CNT_W    = 16;
  localparam int CFG_ADDR = 0;
  localparam int WIDE_ADDR = 1;
  localparam int CH_BASE  = 2;
  localparam int B_ASEL   = 7;
  localparam int B_IEN    = 6;
  localparam int B_FLAG   = 5;

  typedef enum logic [1:0] {LEN8 = 2'd0, LEN9 = 2'd1, LEN10 = 2'd2, LEN11 = 2'd3} len_e;

  function automatic logic [CNT_W-1:0] len_mask(len_e l);
    return CNT_W'((32'd1 << (8 + int'(l))) - 32'd1);
  endfunction
endpackage

// File: rtl/vpwm_counter.sv
module vpwm_counter
  import vpwm_pkg::*;
#(
  parameter int W = CNT_W
) (
  input  logic         clk,
  input  logic         rst_n,
  input  len_e         len_i,
  output logic [W-1:0] cnt_o,
  output logic         wrap_o
);
  logic [W-1:0] cnt_q, cnt_d, mask;

  assign mask   = W'(len_mask(len_i));
  assign wrap_o = (cnt_q & mask) == mask;
  assign cnt_d  = cnt_q + W'(1);
  assign cnt_o  = cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  // After a period boundary, the low bits of the period restart at zero.
  assert_wrap_low_zero_R2: assert property (@(posedge clk) disable iff (!rst_n)
    wrap_o |=> ((cnt_q & $past(mask)) == '0));
endmodule

// File: rtl/vpwm_chan.sv
module vpwm_chan
  import vpwm_pkg::*;
#(
  parameter int W  = CNT_W,
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wide_i,
  input  len_e          len_i,
  input  logic          wrap_i,
  input  logic [W-1:0]  cnt_i,
  input  logic          asel_i,
  input  logic          wr_lo_i,
  input  logic          wr_hi_i,
  input  logic [DW-1:0] wdata_i,
  output logic [W-1:0]  cmp_o,
  output logic [W-1:0]  rld_o,
  output logic          pwm_o
);
  logic [W-1:0] cmp_q, cmp_d, rld_q, rld_d, cnt_m;
  logic         cmp_en, rld_en, reload_go, cmp_wr;

  assign reload_go = wrap_i && !wide_i && (len_i != LEN8);
  assign cmp_wr    = !asel_i && (wr_lo_i || wr_hi_i);
  assign cmp_en    = reload_go || cmp_wr;
  assign rld_en    = asel_i && (wr_lo_i || wr_hi_i);

  always_comb begin
    cmp_d = cmp_q;
    if (reload_go) begin
      cmp_d = rld_q;
    end else begin
      if (wr_lo_i) cmp_d[DW-1:0] = wdata_i;
      if (wr_hi_i) cmp_d[W-1:DW] = wdata_i;
    end
    rld_d = rld_q;
    if (wr_lo_i) rld_d[DW-1:0] = wdata_i;
    if (wr_hi_i) rld_d[W-1:DW] = wdata_i;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cmp_q <= '0;
      rld_q <= '0;
    end else begin
      if (cmp_en) cmp_q <= cmp_d;
      if (rld_en) rld_q <= rld_d;
    end
  end

  assign cnt_m = wide_i ? cnt_i : (cnt_i & W'(len_mask(len_i)));
  assign pwm_o = !(cnt_m < cmp_q);
  assign cmp_o = cmp_q;
  assign rld_o = rld_q;

  assert_reload_copy_R6: assert property (@(posedge clk) disable iff (!rst_n)
    reload_go |=> (cmp_q == $past(rld_q)));

  assert_no_shadow_use_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (wrap_i && (wide_i || len_i == LEN8) && !cmp_wr) |=> $stable(cmp_q));
endmodule

// File: rtl/vpwm_core.sv
module vpwm_core
  import vpwm_pkg::*;
#(
  parameter int NCH    = 4,
  parameter int ADDR_W = 4,
  parameter int DW     = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DW-1:0]     wdata_i,
  input  logic              wr_en_i,
  output logic [DW-1:0]     rdata_o,
  output logic [NCH-1:0]    pwm_o,
  output logic              irq_o
);
  localparam int W = 2 * DW;

  logic [1:0]     rs_q;
  logic           rs_n;
  logic           asel_q, ien_q, flag_q, flag_d;
  len_e           len_q;
  logic [NCH-1:0] wide_q;
  logic           cfg_wr, wide_wr, wrap;
  logic [W-1:0]   cnt;
  logic [W-1:0]   cmp_w [NCH];
  logic [W-1:0]   rld_w [NCH];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rs_q <= 2'b00;
    else        rs_q <= {rs_q[0], 1'b1};
  end
  assign rs_n = rs_q[1];

  assign cfg_wr  = wr_en_i && (addr_i == ADDR_W'(CFG_ADDR));
  assign wide_wr = wr_en_i && (addr_i == ADDR_W'(WIDE_ADDR));

  always_comb begin
    if (wrap)        flag_d = 1'b1;
    else if (cfg_wr) flag_d = wdata_i[B_FLAG];
    else             flag_d = flag_q;
  end

  always_ff @(posedge clk or negedge rs_n) begin
    if (!rs_n) begin
      asel_q <= 1'b0;
      ien_q  <= 1'b0;
      len_q  <= LEN8;
      flag_q <= 1'b0;
      wide_q <= '0;
    end else begin
      flag_q <= flag_d;
      if (cfg_wr) begin
        asel_q <= wdata_i[B_ASEL];
        ien_q  <= wdata_i[B_IEN];
        len_q  <= len_e'(wdata_i[1:0]);
      end
      if (wide_wr) wide_q <= wdata_i[NCH-1:0];
    end
  end

  vpwm_counter #(.W(W)) u_cnt (
    .clk(clk), .rst_n(rs_n), .len_i(len_q), .cnt_o(cnt), .wrap_o(wrap)
  );

  for (genvar g = 0; g < NCH; g++) begin : g_ch
    logic wr_lo, wr_hi;
    assign wr_lo = wr_en_i && (addr_i == ADDR_W'(CH_BASE + 2 * g));
    assign wr_hi = wr_en_i && (addr_i == ADDR_W'(CH_BASE + 2 * g + 1));
    vpwm_chan #(.W(W), .DW(DW)) u_ch (
      .clk(clk), .rst_n(rs_n), .wide_i(wide_q[g]), .len_i(len_q),
      .wrap_i(wrap), .cnt_i(cnt), .asel_i(asel_q),
      .wr_lo_i(wr_lo), .wr_hi_i(wr_hi), .wdata_i(wdata_i),
      .cmp_o(cmp_w[g]), .rld_o(rld_w[g]), .pwm_o(pwm_o[g])
    );
  end

  always_comb begin
    rdata_o = '0;
    if (addr_i == ADDR_W'(CFG_ADDR))
      rdata_o = DW'({asel_q, ien_q, flag_q, 3'b000, len_q});
    else if (addr_i == ADDR_W'(WIDE_ADDR))
      rdata_o = DW'(wide_q);
    for (int i = 0; i < NCH; i++) begin
      if (addr_i == ADDR_W'(CH_BASE + 2 * i))
        rdata_o = asel_q ? rld_w[i][DW-1:0] : cmp_w[i][DW-1:0];
      if (addr_i == ADDR_W'(CH_BASE + 2 * i + 1))
        rdata_o = asel_q ? rld_w[i][W-1:DW] : cmp_w[i][W-1:DW];
    end
  end

  assign irq_o = flag_q & ien_q;

  assert_flag_sticky_R3: assert property (@(posedge clk) disable iff (!rs_n)
    (flag_q && !(cfg_wr && !wdata_i[B_FLAG])) |=> flag_q);

  assert_flag_rise_R2: assert property (@(posedge clk) disable iff (!rs_n)
    $rose(flag_q) |-> $past(wrap || (cfg_wr && wdata_i[B_FLAG])));

  assert_set_wins_R10: assert property (@(posedge clk) disable iff (!rs_n)
    (wrap && cfg_wr && !wdata_i[B_FLAG]) |=> flag_q);

  assert_irq_hold_R4: assert property (@(posedge clk) disable iff (!rs_n)
    (irq_o && !cfg_wr) |=> irq_o);
endmodule

// File: tb/vpwm_core_bench.sv
module vpwm_core_bench;
  localparam int NCH = 4;

  logic           clk = 1'b0;
  logic           rst_n;
  logic [3:0]     addr_i;
  logic [7:0]     wdata_i;
  logic           wr_en_i;
  logic [7:0]     rdata_o;
  logic [NCH-1:0] pwm_o;
  logic           irq_o;

  int vectors = 0;
  int misses  = 0;
  int cyc     = 0;
  bit chk_on  = 1'b0;

  always #10 clk = ~clk;

  vpwm_core u_vpwm_core (
    .clk(clk), .rst_n(rst_n), .addr_i(addr_i), .wdata_i(wdata_i),
    .wr_en_i(wr_en_i), .rdata_o(rdata_o), .pwm_o(pwm_o), .irq_o(irq_o)
  );

  // Reference model, written from the requirements
  int          m_rs;
  logic [15:0] m_cnt;
  logic        m_asel, m_ien, m_flag;
  logic [1:0]  m_len;
  logic [3:0]  m_wide;
  logic [15:0] m_cmp [NCH];
  logic [15:0] m_rld [NCH];

  function automatic logic [15:0] bmask(logic [1:0] l);
    return 16'((32'd1 << (8 + int'(l))) - 32'd1);
  endfunction

  function automatic logic exp_pwm(int ch);
    logic [15:0] v;
    v = m_wide[ch] ? m_cnt : (m_cnt & bmask(m_len));
    return !(v < m_cmp[ch]);
  endfunction

  function automatic logic [7:0] exp_read(logic [3:0] a);
    if (a == 4'd0) return {m_asel, m_ien, m_flag, 3'b000, m_len};
    if (a == 4'd1) return {4'b0, m_wide};
    for (int i = 0; i < NCH; i++) begin
      if (a == 4'(2 + 2 * i)) return m_asel ? m_rld[i][7:0]  : m_cmp[i][7:0];
      if (a == 4'(3 + 2 * i)) return m_asel ? m_rld[i][15:8] : m_cmp[i][15:8];
    end
    return 8'h00;
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_rs = 0; m_cnt = 0; m_asel = 0; m_ien = 0; m_flag = 0; m_len = 0; m_wide = 0;
      for (int i = 0; i < NCH; i++) begin m_cmp[i] = 0; m_rld[i] = 0; end
    end else if (m_rs < 2) begin
      m_rs = m_rs + 1;   // R11: synchroniser stages
    end else begin
      logic evt, asel0;
      logic [1:0] len0;
      logic [15:0] rld0 [NCH];
      evt = (m_cnt & bmask(m_len)) == bmask(m_len);
      asel0 = m_asel; len0 = m_len;
      for (int i = 0; i < NCH; i++) rld0[i] = m_rld[i];
      for (int i = 0; i < NCH; i++) begin
        logic lo, hi;
        lo = wr_en_i && addr_i == 4'(2 + 2 * i);
        hi = wr_en_i && addr_i == 4'(3 + 2 * i);
        if (evt && !m_wide[i] && len0 != 2'd0) m_cmp[i] = rld0[i];
        else if (!asel0) begin
          if (lo) m_cmp[i][7:0]  = wdata_i;
          if (hi) m_cmp[i][15:8] = wdata_i;
        end
        if (asel0) begin
          if (lo) m_rld[i][7:0]  = wdata_i;
          if (hi) m_rld[i][15:8] = wdata_i;
        end
      end
      if (evt) m_flag = 1;
      else if (wr_en_i && addr_i == 0) m_flag = wdata_i[5];
      if (wr_en_i && addr_i == 0) begin
        m_asel = wdata_i[7]; m_ien = wdata_i[6]; m_len = wdata_i[1:0];
      end
      if (wr_en_i && addr_i == 1) m_wide = wdata_i[3:0];
      m_cnt = m_cnt + 1;
    end
  end

  task automatic chk(string tag, logic [15:0] act, logic [15:0] exp);
    vectors++;
    if (act !== exp) begin
      misses++;
      $display("FAIL %s: actual %h expected %h at cycle %0d", tag, act, exp, cyc);
    end
  endtask

  task automatic summary();
    $display("  == %0d vectors applied, %0d miscompares ==", vectors, misses);
    $finish;
  endtask

  // Continuous comparison against the model, sampled after each edge
  always @(posedge clk) begin
    #5;
    if (chk_on) begin
      for (int i = 0; i < NCH; i++)
        chk(m_wide[i] ? "R8 pwm wide" : "R1 pwm", 16'(pwm_o[i]), 16'(exp_pwm(i)));
      chk("R4 irq", 16'(irq_o), 16'(m_flag & m_ien));
      chk(addr_i == 0 ? "R9 ctrl read" : (addr_i == 1 ? "R8 mode read" : "R5 read"),
          16'(rdata_o), 16'(exp_read(addr_i)));
    end
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000) begin
      misses++;
      $display("FAIL watchdog: actual %0d expected below 150000 cycles", cyc);
      summary();
    end
  end

  task automatic drive(logic [3:0] a, logic [7:0] d, logic w);
    @(negedge clk);
    addr_i = a; wdata_i = d; wr_en_i = w;
  endtask

  task automatic sample();
    @(posedge clk);
    #5;
  endtask

  task automatic wait_flag();
    do begin
      drive(4'd0, 8'h00, 1'b0);
      sample();
    end while (!rdata_o[5]);
  endtask

  initial begin
    void'($urandom(32'd20240611));
    rst_n = 0; addr_i = 0; wdata_i = 0; wr_en_i = 0;
    #15;
    chk("R9 reset ctrl", 16'(rdata_o), 16'h0);
    chk("R9 reset irq", 16'(irq_o), 16'h0);
    addr_i = 4'd2;
    #1 chk("R9 reset compare", 16'(rdata_o), 16'h0);
    addr_i = 4'd0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1;
    chk_on = 1;
    // R11/R2: first overflow edge is the 258th edge after release
    repeat (257) @(posedge clk);
    #5 chk("R11 flag before first wrap", 16'(rdata_o[5]), 16'h0);
    sample();
    chk("R2 flag at first wrap", 16'(rdata_o[5]), 16'h1);
    chk("R9 unused bits", 16'(rdata_o[4:2]), 16'h0);

    // R3 sticky flag: software clear, then software set
    drive(4'd0, 8'h00, 1'b1); sample();
    chk("R3 flag cleared", 16'(rdata_o[5]), 16'h0);
    drive(4'd0, 8'h3C, 1'b1); sample();
    chk("R3 flag set by write", 16'(rdata_o[5]), 16'h1);
    chk("R9 unused ignored", 16'(rdata_o[4:2]), 16'h0);
    drive(4'd0, 8'h00, 1'b0); sample();
    chk("R3 flag holds", 16'(rdata_o[5]), 16'h1);
    chk("R4 irq masked", 16'(irq_o), 16'h0);
    drive(4'd0, 8'h60, 1'b1); sample();
    chk("R4 irq enabled", 16'(irq_o), 16'h1);

    // R10: clearing write on the overflow edge
    do @(negedge clk); while (m_cnt[7:0] != 8'hFF);
    addr_i = 4'd0; wdata_i = 8'h40; wr_en_i = 1'b1;
    sample();
    chk("R10 set beats clear", 16'(rdata_o[5]), 16'h1);

    // R6: shadow load in 9-bit mode
    drive(4'd0, 8'h01, 1'b1);
    drive(4'd2, 8'h10, 1'b1);
    drive(4'd3, 8'h00, 1'b1);
    drive(4'd0, 8'h81, 1'b1);
    drive(4'd2, 8'h34, 1'b1);
    drive(4'd3, 8'h01, 1'b1);
    drive(4'd0, 8'h01, 1'b1);
    wait_flag();
    drive(4'd3, 8'h00, 1'b0); sample();
    chk("R6 reload high byte", 16'(rdata_o), 16'h01);
    drive(4'd2, 8'h00, 1'b0); sample();
    chk("R6 reload low byte", 16'(rdata_o), 16'h34);
    drive(4'd0, 8'h81, 1'b1);
    drive(4'd2, 8'h00, 1'b0); sample();
    chk("R5 shadow view", 16'(rdata_o), 16'h34);

    // R7: no load in 8-bit mode
    drive(4'd2, 8'h77, 1'b1);
    drive(4'd0, 8'h00, 1'b1);
    wait_flag();
    drive(4'd2, 8'h00, 1'b0); sample();
    chk("R7 no load in 8-bit", 16'(rdata_o), 16'h34);

    // R8: wide channel ignores length and shadow
    drive(4'd1, 8'h02, 1'b1);
    drive(4'd4, 8'h00, 1'b1);
    drive(4'd5, 8'h09, 1'b1);
    drive(4'd0, 8'h83, 1'b1);
    drive(4'd5, 8'h55, 1'b1);
    drive(4'd0, 8'h03, 1'b1);
    wait_flag();
    drive(4'd5, 8'h00, 1'b0); sample();
    chk("R8 wide keeps compare", 16'(rdata_o), 16'h09);

    // Random phase
    for (int i = 0; i < 30000; i++) begin
      logic [3:0] a;
      logic [7:0] d;
      logic w;
      int r;
      r = int'($urandom % 100);
      w = (r < 30);
      d = 8'($urandom);
      if ($urandom % 200 == 0) a = 4'd0;
      else if ($urandom % 100 == 0) a = 4'd1;
      else a = 4'(2 + $urandom % 12);
      if (a == 4'd0 && w) d[7] = ($urandom % 3 == 0);
      if (a[0] && a >= 4'd3 && w) d = 8'($urandom % 9);
      drive(a, d, w);
    end
    drive(4'd0, 8'h00, 1'b0);
    repeat (3) @(posedge clk);
    #6;
    summary();
  end
endmodule